// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Counting Timer

This unit holds three independent 32-bit timer channels behind a small synchronous register bus. Each channel has a reload value, a live down-counter and a control word. A channel counts only while its bit in the shared run register is set. It decrements once per prescaler tick, and the tick rate is the bus clock divided by 4, 16, 64, 256 or 1024. When a tick arrives with the counter at zero, the counter takes the reload value, a sticky underflow flag is set, and the channel's interrupt line rises if the interrupt is enabled. Periodic operation therefore repeats with no software help. A free-running count from all ones gives elapsed ticks as the bitwise inverse of the counter.

Each channel is a two-state machine. `CH_HALT` is the state after reset. The transition named GO, a run-register write with the channel's bit at one, moves it to `CH_RUN`. The transition named HALT, a run-register write with the bit at zero, moves it back to `CH_HALT`. A run-register write returns a channel to the state it is already in when its bit matches that state. The run register reads back the current state of every channel. Leaving `CH_RUN` clears the channel's prescaler, so every GO starts a full prescaler period.

Top module: `tmr_unit`

## Requirements
- R1: Bit n of the run register (byte address 0x00, bits 2:0) puts channel n in CH_RUN when written 1 and in CH_HALT when written 0. A halted channel's counter holds its value, and the other channels are not affected.
- R2: Control bits 2:0 select the tick period: 0→4, 1→16, 2→64, 3→256, 4→1024 clocks, and 5 to 7 behave as 0. The first tick after GO comes a full period after the run-register write.
- R3: Each tick decrements the counter by one. Starting from 0xFFFFFFFF, the bitwise inverse of the counter equals the number of ticks.
- R4: A tick that finds the counter at zero reloads it from the channel's reload register and sets the underflow flag (control bit 8). A counter loaded with N underflows on tick N+1.
- R5: A control write whose byte 1 is enabled and has bit 8 at 0 clears the flag. Bit 8 at 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R6: irq[n] is high exactly while channel n's flag and its interrupt enable (control bit 5) are both set.
- R7: Channel n's registers sit at byte address 4+12n: reload at +0, counter at +4, control at +8. Unmapped addresses read zero.
- R8: A write changes only the bytes whose byte enable is set. A run-register write with byte 0 disabled has no effect.
- R9: After reset the run register and the control registers read zero, reload and counter registers read 0xFFFFFFFF, and all irq lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel interrupt, level |

## Verification
The assertions assume the bus holds at most one write per cycle and that bus_we, bus_addr and the other bus inputs are never unknown after reset. A clearing write and an underflow may land in the same cycle, and the priority check relies on exactly that. The bench drives every bus input at the falling edge and returns bus_we to zero after each single-cycle write, so no write ever spans two edges. It counts cycles from the run-register write so that underflows and clearing writes fall on known edges, and it never changes the prescaler select of a running channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH    = 3;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int BE_W      = DATA_W / 8;
    localparam int SEL_W     = 3;
    localparam int PSC_W     = 10;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 12;
    localparam int FLAG_BIT  = 8;
    localparam int IE_BIT    = 5;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        SUB_RELOAD = 2'd0,
        SUB_COUNT  = 2'd1,
        SUB_CTRL   = 2'd2
    } ch_sub_e;

    // Terminal count of the prescaler for each select value (period minus one).
    function automatic logic [PSC_W-1:0] psc_last(input logic [SEL_W-1:0] sel);
        logic [PSC_W-1:0] r;
        unique case (sel)
            3'd1:    r = 10'd15;
            3'd2:    r = 10'd63;
            3'd3:    r = 10'd255;
            3'd4:    r = 10'd1023;
            default: r = 10'd3;
        endcase
        return r;
    endfunction

    // Byte-lane merge of a write into an existing register value.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] last;

    assign last = psc_last(sel);
    assign tick = run && (pcnt_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              start_bit,
    input  logic              reload_we,
    input  logic              count_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              running,
    output logic              uf,
    output logic              flag,
    output logic              irq
);

    ch_state_e        state_q, state_d;
    logic [DATA_W-1:0] reload_q, count_q;
    logic [SEL_W-1:0]  sel_q;
    logic              ie_q, flag_q;
    logic              tick;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // Next state: GO and HALT arcs, taken on a run-register write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (start_we && start_bit)  state_d = CH_RUN;
            CH_RUN:  if (start_we && !start_bit) state_d = CH_HALT;
            default: state_d = CH_HALT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            CH_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end

    tmr_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .sel   (sel_q),
        .tick  (tick)
    );

    assign uf = tick && (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            count_q  <= '1;
            sel_q    <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (reload_we) reload_q <= lane_merge(reload_q, wdata, be);

            if (count_we)  count_q <= lane_merge(count_q, wdata, be);
            else if (uf)   count_q <= reload_q;
            else if (tick) count_q <= count_q - 1'b1;

            if (ctrl_we && be[0]) begin
                sel_q <= wdata[SEL_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end

            if (uf)                                       flag_q <= 1'b1;
            else if (ctrl_we && be[1] && !wdata[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_o              = '0;
        ctrl_o[SEL_W-1:0]   = sel_q;
        ctrl_o[IE_BIT]      = ie_q;
        ctrl_o[FLAG_BIT]    = flag_q;
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign flag     = flag_q;
    assign irq      = flag_q && ie_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [DATA_W-1:0] reload_a [NUM_CH];
    logic [DATA_W-1:0] count_a  [NUM_CH];
    logic [DATA_W-1:0] ctrl_a   [NUM_CH];

    logic [NUM_CH-1:0]        run_vec, uf_vec, flag_vec, cnt_wr, ctl_wr, rld_wr;
    logic [NUM_CH*DATA_W-1:0] cnt_flat, rld_flat;
    logic                     start_we;

    assign start_we = bus_we && (bus_addr == '0) && bus_be[0];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE*n);

        assign rld_wr[n] = bus_we && (bus_addr == BASE + ADDR_W'(4*SUB_RELOAD));
        assign cnt_wr[n] = bus_we && (bus_addr == BASE + ADDR_W'(4*SUB_COUNT));
        assign ctl_wr[n] = bus_we && (bus_addr == BASE + ADDR_W'(4*SUB_CTRL));

        tmr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_we  (start_we),
            .start_bit (bus_wdata[n]),
            .reload_we (rld_wr[n]),
            .count_we  (cnt_wr[n]),
            .ctrl_we   (ctl_wr[n]),
            .wdata     (bus_wdata),
            .be        (bus_be),
            .reload_o  (reload_a[n]),
            .count_o   (count_a[n]),
            .ctrl_o    (ctrl_a[n]),
            .running   (run_vec[n]),
            .uf        (uf_vec[n]),
            .flag      (flag_vec[n]),
            .irq       (irq[n])
        );

        assign cnt_flat[n*DATA_W +: DATA_W] = count_a[n];
        assign rld_flat[n*DATA_W +: DATA_W] = reload_a[n];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata[NUM_CH-1:0] = run_vec;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n + 4*SUB_RELOAD)) bus_rdata = reload_a[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n + 4*SUB_COUNT))  bus_rdata = count_a[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n + 4*SUB_CTRL))   bus_rdata = ctrl_a[n];
        end
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH-1:0]        run_vec,
    input logic [NUM_CH-1:0]        uf_vec,
    input logic [NUM_CH-1:0]        flag_vec,
    input logic [NUM_CH-1:0]        cnt_wr,
    input logic [NUM_CH-1:0]        ctl_wr,
    input logic [NUM_CH*DATA_W-1:0] cnt_flat,
    input logic [NUM_CH*DATA_W-1:0] rld_flat
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_a
        AST_HALT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[n] && !cnt_wr[n]) |=> $stable(cnt_flat[n*DATA_W +: DATA_W])); // R1

        AST_UF_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_vec[n] && !cnt_wr[n]) |=> (cnt_flat[n*DATA_W +: DATA_W] == $past(rld_flat[n*DATA_W +: DATA_W]))); // R4

        AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            uf_vec[n] |=> flag_vec[n]); // R5

        AST_FLAG_ONLY_FROM_UF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[n]) |-> $past(uf_vec[n])); // R4

        AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[n] && !ctl_wr[n]) |=> irq[n]); // R6

        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq[n] |-> flag_vec[n]); // R6
    end

endmodule

bind tmr_unit tmr_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .run_vec  (run_vec),
    .uf_vec   (uf_vec),
    .flag_vec (flag_vec),
    .cnt_wr   (cnt_wr),
    .ctl_wr   (ctl_wr),
    .cnt_flat (cnt_flat),
    .rld_flat (rld_flat)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    tmr_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [5:0] a_rld(input int n); return 6'(4 + 12*n); endfunction
    function automatic logic [5:0] a_cnt(input int n); return 6'(8 + 12*n); endfunction
    function automatic logic [5:0] a_ctl(input int n); return 6'(12 + 12*n); endfunction

    // Vector table: prescaler select, loaded count, tick period
    localparam int NV = 6;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 5};
    localparam int V_N   [NV] = '{2, 1, 0, 0, 0, 1};
    localparam int V_DIV [NV] = '{4, 16, 64, 256, 1024, 4};

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, hold0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(6'h00, v);       chk("R9 run reg", v, 32'h0);
        rd(a_rld(0), v);    chk("R9 reload", v, 32'hFFFF_FFFF);
        rd(a_cnt(2), v);    chk("R9 counter", v, 32'hFFFF_FFFF);
        rd(a_ctl(1), v);    chk("R9 control", v, 32'h0);
        chk("R9 irq", {29'b0, irq}, 32'h0);
        // R7 unmapped
        rd(6'h28, v);       chk("R7 unmapped", v, 32'h0);

        // Vector walk on channel 0: R2 period, R4 reload and underflow timing, R6 irq
        for (int i = 0; i < NV; i++) begin
            int exp_cyc;
            exp_cyc = (V_N[i] + 1) * V_DIV[i];
            wr(6'h00, 32'h0, 4'hF);
            wr(a_ctl(0), 32'h20 | 32'(V_SEL[i]), 4'hF);
            wr(a_rld(0), 32'h100 + 32'(i), 4'hF);
            wr(a_cnt(0), 32'(V_N[i]), 4'hF);
            wr(6'h00, 32'h1, 4'hF);
            wait_cyc(exp_cyc - 1);
            rd(a_ctl(0), v);
            chk($sformatf("R2 no flag before period sel %0d", V_SEL[i]), {31'b0, v[8]}, 32'h0);
            wait_cyc(1);
            rd(a_ctl(0), v);
            chk($sformatf("R4 flag at underflow sel %0d", V_SEL[i]), {31'b0, v[8]}, 32'h1);
            chk($sformatf("R6 irq at underflow sel %0d", V_SEL[i]), {31'b0, irq[0]}, 32'h1);
            rd(a_cnt(0), v);
            chk($sformatf("R4 reload value sel %0d", V_SEL[i]), v, 32'h100 + 32'(i));
        end

        // R1 halt channel 0, run channel 1 only; R3 elapsed ticks
        wr(6'h00, 32'h2, 4'hF);
        rd(a_cnt(0), hold0);
        wait_cyc(40);
        rd(a_cnt(1), v);    chk("R3 elapsed ticks", ~v, 32'd10);
        rd(a_cnt(0), v);    chk("R1 halted ch0 holds", v, hold0);
        rd(a_cnt(2), v);    chk("R1 ch2 untouched", v, 32'hFFFF_FFFF);
        rd(6'h00, v);       chk("R1 run reg readback", v, 32'h2);
        wr(6'h00, 32'h0, 4'hF);
        rd(a_cnt(1), hold0);
        wait_cyc(20);
        rd(a_cnt(1), v);    chk("R1 halt holds ch1", v, hold0);

        // R5 write-one keeps flag, R6 enable gating, R5 write-zero clears
        wr(a_ctl(0), 32'h120, 4'hF);
        rd(a_ctl(0), v);    chk("R5 write one keeps flag", {31'b0, v[8]}, 32'h1);
        wr(a_ctl(0), 32'h100, 4'hF);
        chk("R6 irq off when disabled", {29'b0, irq}, 32'h0);
        wr(a_ctl(0), 32'h20, 4'hF);
        rd(a_ctl(0), v);    chk("R5 write zero clears", v, 32'h20);
        chk("R6 irq low after clear", {31'b0, irq[0]}, 32'h0);

        // R8 byte enables
        wr(a_rld(0), 32'hAABB_CCDD, 4'b0001);
        rd(a_rld(0), v);    chk("R8 reload byte lane", v, 32'h0000_01DD);
        wr(6'h00, 32'h1, 4'b0000);
        rd(6'h00, v);       chk("R8 run write without lane", v, 32'h0);

        // R5 underflow beats a clearing write in the same cycle
        wr(a_ctl(2), 32'h0, 4'hF);
        wr(a_cnt(2), 32'h0, 4'hF);
        wr(6'h00, 32'h4, 4'hF);
        wait_cyc(3);
        wr(a_ctl(2), 32'h0, 4'hF);
        rd(a_ctl(2), v);    chk("R5 underflow wins over clear", {31'b0, v[8]}, 32'h1);
        chk("R6 irq needs enable", {31'b0, irq[2]}, 32'h0);

        // R2 prescaler restarts on GO
        wr(6'h00, 32'h0, 4'hF);
        wr(a_cnt(2), 32'd5, 4'hF);
        wr(6'h00, 32'h4, 4'hF);
        wait_cyc(3);
        rd(a_cnt(2), v);    chk("R2 no tick before full period", v, 32'd5);
        wait_cyc(1);
        rd(a_cnt(2), v);    chk("R2 first tick after GO", v, 32'd4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule